// File: doc/BRIEF.md
# Two-Port Queue/RAM Block with Parity

This block is a 256-word by 9-bit storage array with one write port and one read port, and both ports may be used in the same cycle. A mode input picks how the array is addressed. In addressed-RAM mode the caller supplies the write and read addresses. In queue mode the block keeps its own write and read pointers and an occupancy count, and it ignores the address inputs. The status pins (full, empty, almost-full, almost-empty and the count) let a surrounding design place several blocks side by side to make wider words, or stack them to make deeper queues.

Each port has its own elaboration-time timing option. A registered write port takes the request one cycle before it reaches the array. A direct write port commits the request on the edge where it is presented. A registered read port returns data on the cycle after the request. A combinational read port shows the word at the read address, or the queue head, without waiting for a clock edge. When parity is enabled, the write side computes the ninth bit from the lower eight bits, and the read side flags any word whose stored ninth bit does not match. The port-level interface is plain enable-based. There is no back-pressure handshake: a caller must watch `full` and `empty`, and a request that is refused in queue mode is dropped and reported by a pulse.

Top module: `twoport_qram`

## Requirements
- R1: While `rst_n` is low at a clock edge, and on the cycle after it, `fill_count` is 0, `empty` is 1, and `full`, `rd_valid`, `overflow` and `underflow` are 0.
- R2: In RAM mode (`fifo_mode`=0), a write with `wr_en`=1 stores the word at `wr_addr`. With the registered read port, a read with `rd_en`=1 at an edge presents the word stored at `rd_addr` on `rd_data`, with `rd_valid`=1, in the cycle after that edge. In RAM mode `fill_count` stays unchanged.
- R3: With `RD_REG`=0, `rd_data` shows the word at the read address combinationally and `rd_valid` follows `rd_en`. With `WR_REG`=1, a write reaches the array one clock edge later than it does with `WR_REG`=0.
- R4: In queue mode (`fifo_mode`=1), words come out in the order they went in, and `wr_addr`/`rd_addr` have no effect. `fill_count` runs from 0 to 256. `full` is 1 exactly at 256 and `empty` is 1 exactly at 0, and the two are never both 1.
- R5: In queue mode, a write while `full` or a read while `empty` is dropped and neither pointer moves. The cycle after the attempt, `overflow` or `underflow` (respectively) is 1 for exactly one cycle, and `rd_valid` stays 0 for a dropped read.
- R6: `almost_full` is 1 when `fill_count` >= `af_thr`, and `almost_empty` is 1 when `fill_count` <= `ae_thr`. Both thresholds are 8-bit and are sampled continuously.
- R7: With `par_en`=1, the stored bit 8 equals the XOR of bits 7:0, inverted when `par_odd`=1. With `par_en`=0, bit 8 of `wr_data` is stored unchanged.
- R8: `rd_par_err` is 1 together with valid read data when `par_en`=1 and the returned bit 8 differs from the XOR of bits 7:0 (inverted for `par_odd`=1). Otherwise it is 0.
- R9: In queue mode, an accepted read and an accepted write in the same cycle leave `fill_count` unchanged. A read and a write to an empty queue in the same cycle accept only the write, so the new word is not passed to the output that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_mode | input | 1 | 0 = addressed RAM, 1 = queue |
| par_en | input | 1 | Enables parity generation and checking |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| wr_en | input | 1 | Write request |
| wr_addr | input | 8 | Write address (RAM mode only) |
| wr_data | input | 9 | Write word; bit 8 is used only when parity is off |
| rd_en | input | 1 | Read request |
| rd_addr | input | 8 | Read address (RAM mode only) |
| af_thr | input | 8 | Almost-full threshold |
| ae_thr | input | 8 | Almost-empty threshold |
| rd_data | output | 9 | Read word |
| rd_valid | output | 1 | `rd_data` holds an accepted read |
| rd_par_err | output | 1 | Parity mismatch on the current read word |
| fill_count | output | 9 | Queue occupancy, 0..256 |
| full | output | 1 | Occupancy is 256 |
| empty | output | 1 | Occupancy is 0 |
| almost_full | output | 1 | Occupancy at or above `af_thr` |
| almost_empty | output | 1 | Occupancy at or below `ae_thr` |
| overflow | output | 1 | One-cycle pulse after a dropped write |
| underflow | output | 1 | One-cycle pulse after a dropped read |

## Verification
Two functions can land in the same edge: a queue write and a queue read. The bench drives both at a steady half-full level for a run of cycles. It expects the count to hold and the words to leave in their arrival order, with the expected values computed from the data pattern. It also drives a read and a write together on an empty queue, where only the write may be accepted. There the bench expects a count of one, an underflow pulse, no valid data that cycle, and the new word appearing only on the following read.

// File: rtl/qram_pkg.sv
package qram_pkg;
  typedef enum logic {
    MODE_RAM  = 1'b0,
    MODE_FIFO = 1'b1
  } qram_mode_e;

  localparam int QRAM_DEPTH  = 256;
  localparam int QRAM_DATA_W = 8;
endpackage

// File: rtl/qram_parity.sv
module qram_parity #(
  parameter int DATA_W = 8
) (
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [DATA_W:0]   wr_word_i,
  output logic [DATA_W:0]   wr_word_o,
  input  logic [DATA_W:0]   rd_word_i,
  input  logic              rd_valid_i,
  output logic              rd_err_o
);
  logic gen_bit;
  logic chk_bit;

  assign gen_bit   = (^wr_word_i[DATA_W-1:0]) ^ par_odd;
  assign wr_word_o = par_en ? {gen_bit, wr_word_i[DATA_W-1:0]} : wr_word_i;

  assign chk_bit   = (^rd_word_i[DATA_W-1:0]) ^ par_odd;
  assign rd_err_o  = rd_valid_i && par_en && (chk_bit != rd_word_i[DATA_W]);
endmodule

// File: rtl/qram_wr_stage.sv
module qram_wr_stage #(
  parameter int  AW  = 8,
  parameter int  WW  = 9,
  parameter bit  REG = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [WW-1:0] word_i,
  output logic          en_o,
  output logic [AW-1:0] addr_o,
  output logic [WW-1:0] word_o
);
  generate
    if (REG) begin : g_reg
      logic          en_q;
      logic [AW-1:0] addr_q;
      logic [WW-1:0] word_q;
      always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_i;
        addr_q <= addr_i;
        word_q <= word_i;
      end
      assign en_o   = en_q;
      assign addr_o = addr_q;
      assign word_o = word_q;
    end else begin : g_direct
      logic unused_clkrst;
      assign unused_clkrst = clk ^ rst_n;
      assign en_o   = en_i;
      assign addr_o = addr_i;
      assign word_o = word_i;
    end
  endgenerate
endmodule

// File: rtl/qram_ctrl.sv
module qram_ctrl #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_fifo,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic [AW-1:0] af_thr,
  input  logic [AW-1:0] ae_thr,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          af,
  output logic          ae,
  output logic          ovf,
  output logic          unf
);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  assign full  = (count == CNT_MAX);
  assign empty = (count == '0);
  assign af    = (count >= {1'b0, af_thr});
  assign ae    = (count <= {1'b0, ae_thr});

  assign wr_ok = wr_req && !(is_fifo && full);
  assign rd_ok = rd_req && !(is_fifo && empty);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else begin
      ovf <= is_fifo && wr_req && full;
      unf <= is_fifo && rd_req && empty;
      if (is_fifo) begin
        if (wr_ok) wptr <= wptr + 1'b1;
        if (rd_ok) rptr <= rptr + 1'b1;
        unique case ({wr_ok, rd_ok})
          2'b10:   count <= count + 1'b1;
          2'b01:   count <= count - 1'b1;
          default: count <= count;
        endcase
      end
    end
  end
endmodule

// File: rtl/qram_array.sv
module qram_array #(
  parameter int DEPTH  = 256,
  parameter int WW     = 9,
  parameter bit RD_REG = 1'b1,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wword,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] word_o,
  output logic          valid_o
);
  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wword;
  end

  generate
    if (RD_REG) begin : g_sync_rd
      logic [WW-1:0] word_q;
      logic          valid_q;
      always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= re;
        if (re) word_q <= mem[raddr];
      end
      assign word_o  = word_q;
      assign valid_o = valid_q;
    end else begin : g_async_rd
      logic unused_rst;
      assign unused_rst = rst_n;
      assign word_o  = mem[raddr];
      assign valid_o = re;
    end
  endgenerate
endmodule

// File: rtl/twoport_qram.sv
module twoport_qram
  import qram_pkg::*;
#(
  parameter int DEPTH  = QRAM_DEPTH,
  parameter int DATA_W = QRAM_DATA_W,
  parameter bit WR_REG = 1'b0,
  parameter bit RD_REG = 1'b1,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1,
  localparam int WW    = DATA_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_mode,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [WW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] af_thr,
  input  logic [AW-1:0] ae_thr,
  output logic [WW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rd_par_err,
  output logic [CW-1:0] fill_count,
  output logic          full,
  output logic          empty,
  output logic          almost_full,
  output logic          almost_empty,
  output logic          overflow,
  output logic          underflow
);
  qram_mode_e    mode;
  logic          is_fifo;
  logic [WW-1:0] gen_word;
  logic          st_en;
  logic [AW-1:0] st_addr;
  logic [WW-1:0] st_word;
  logic          wr_ok;
  logic          rd_ok;
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;
  logic [AW-1:0] mem_waddr;
  logic [AW-1:0] mem_raddr;

  assign mode    = qram_mode_e'(fifo_mode);
  assign is_fifo = (mode == MODE_FIFO);

  qram_parity #(.DATA_W(DATA_W)) u_par (
    .par_en     (par_en),
    .par_odd    (par_odd),
    .wr_word_i  (wr_data),
    .wr_word_o  (gen_word),
    .rd_word_i  (rd_data),
    .rd_valid_i (rd_valid),
    .rd_err_o   (rd_par_err)
  );

  qram_wr_stage #(.AW(AW), .WW(WW), .REG(WR_REG)) u_wst (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (wr_en),
    .addr_i (wr_addr),
    .word_i (gen_word),
    .en_o   (st_en),
    .addr_o (st_addr),
    .word_o (st_word)
  );

  qram_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .is_fifo (is_fifo),
    .wr_req  (st_en),
    .rd_req  (rd_en),
    .af_thr  (af_thr),
    .ae_thr  (ae_thr),
    .wr_ok   (wr_ok),
    .rd_ok   (rd_ok),
    .wptr    (wptr),
    .rptr    (rptr),
    .count   (fill_count),
    .full    (full),
    .empty   (empty),
    .af      (almost_full),
    .ae      (almost_empty),
    .ovf     (overflow),
    .unf     (underflow)
  );

  assign mem_waddr = is_fifo ? wptr : st_addr;
  assign mem_raddr = is_fifo ? rptr : rd_addr;

  qram_array #(.DEPTH(DEPTH), .WW(WW), .RD_REG(RD_REG)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_ok),
    .waddr   (mem_waddr),
    .wword   (st_word),
    .re      (rd_ok),
    .raddr   (mem_raddr),
    .word_o  (rd_data),
    .valid_o (rd_valid)
  );
endmodule

module qram_chk #(
  parameter int DEPTH = 256,
  parameter int CW    = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_mode,
  input logic [CW-1:0] count,
  input logic          full,
  input logic          empty,
  input logic          af,
  input logic          ovf,
  input logic          unf,
  input logic          wr_ok,
  input logic          rd_ok,
  input logic          rd_valid,
  input logic          rd_par_err
);
  // R4
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  // R4
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R4
  count_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && wr_ok && !rd_ok) |=> (count == $past(count) + 1'b1));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> ($past(fifo_mode) && $past(full)));

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> ($past(fifo_mode) && $past(empty)));

  // R6
  full_implies_af_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> af);

  // R8
  par_err_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_par_err |-> rd_valid);

  // R9
  rw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && wr_ok && rd_ok) |=> $stable(count));
endmodule

bind twoport_qram qram_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_mode  (fifo_mode),
  .count      (fill_count),
  .full       (full),
  .empty      (empty),
  .af         (almost_full),
  .ovf        (overflow),
  .unf        (underflow),
  .wr_ok      (wr_ok),
  .rd_ok      (rd_ok),
  .rd_valid   (rd_valid),
  .rd_par_err (rd_par_err)
);

// File: tb/twoport_qram_bench.sv
module twoport_qram_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, fifo_mode, par_en, par_odd, wr_en, rd_en;
  logic [7:0] wr_addr, rd_addr, af_thr, ae_thr;
  logic [8:0] wr_data;
  logic [8:0] rd_data, rd_data2, fill_count, fill_count2;
  logic rd_valid, rd_par_err, full, empty, almost_full, almost_empty, overflow, underflow;
  logic rd_valid2, rd_par_err2, full2, empty2, af2, ae2, ovf2, unf2;

  int total = 0;
  int bad = 0;

  twoport_qram u_twoport_qram (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .par_en(par_en), .par_odd(par_odd),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .af_thr(af_thr), .ae_thr(ae_thr), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_par_err(rd_par_err), .fill_count(fill_count), .full(full), .empty(empty),
    .almost_full(almost_full), .almost_empty(almost_empty), .overflow(overflow),
    .underflow(underflow)
  );

  twoport_qram #(.WR_REG(1'b1), .RD_REG(1'b0)) u_twoport_qram_alt (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .par_en(par_en), .par_odd(par_odd),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .af_thr(af_thr), .ae_thr(ae_thr), .rd_data(rd_data2), .rd_valid(rd_valid2),
    .rd_par_err(rd_par_err2), .fill_count(fill_count2), .full(full2), .empty(empty2),
    .almost_full(af2), .almost_empty(ae2), .overflow(ovf2), .underflow(unf2)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fifo_mode = 1'b0; par_en = 1'b0; par_odd = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; wr_addr = '0; rd_addr = '0; wr_data = '0;
    af_thr = 8'd250; ae_thr = 8'd3;
    @(negedge clk);
    repeat (3) tick();
    // R1 reset state
    check("R1 count", fill_count, 0);
    check("R1 empty", empty, 1);
    check("R1 full", full, 0);
    check("R1 valid", rd_valid, 0);
    check("R1 ovf/unf", {overflow, underflow}, 0);
    rst_n = 1'b1;
    tick();
    check("R1 count after release", fill_count, 0);

    // R2 RAM sweep with even parity generation (R7)
    par_en = 1'b1; par_odd = 1'b0;
    for (int a = 0; a < 256; a++) begin
      wr_en = 1'b1; wr_addr = 8'(a); wr_data = {1'b1, pat(a)};
      tick();
    end
    wr_en = 1'b0;
    tick();
    check("R2 count unchanged in RAM mode", fill_count, 0);
    for (int a = 0; a < 256; a++) begin
      rd_en = 1'b1; rd_addr = 8'(a);
      #1;
      // R3 combinational read on the alternate port
      check("R3 async read word", rd_data2, {^pat(a), pat(a)});
      check("R3 async valid", rd_valid2, 1);
      tick();
      check("R2 sync read word", rd_data, {^pat(a), pat(a)});
      check("R2 valid", rd_valid, 1);
      check("R8 no parity error", rd_par_err, 0);
    end
    rd_en = 1'b0;
    tick();
    check("R2 valid drops", rd_valid, 0);

    // R7 odd parity
    par_odd = 1'b1; wr_en = 1'b1; wr_addr = 8'd3; wr_data = {1'b0, 8'h5A};
    tick();
    wr_en = 1'b0; rd_en = 1'b1; rd_addr = 8'd3;
    tick();
    check("R7 odd parity bit", rd_data, {1'b1, 8'h5A});
    check("R8 odd parity clean", rd_par_err, 0);

    // R7 raw bit kept without parity; R8 mismatch flagged
    rd_en = 1'b0; par_en = 1'b0; par_odd = 1'b0;
    wr_en = 1'b1; wr_addr = 8'd4; wr_data = 9'h100;
    tick();
    wr_en = 1'b0; rd_en = 1'b1; rd_addr = 8'd4;
    tick();
    check("R7 raw bit stored", rd_data, 9'h100);
    check("R8 checking off", rd_par_err, 0);
    par_en = 1'b1;
    #1;
    check("R8 mismatch flagged", rd_par_err, 1);
    rd_en = 1'b0;
    tick();
    check("R8 no error without valid", rd_par_err, 0);

    // R3 registered write lands one edge later
    rd_addr = 8'd7; wr_en = 1'b1; wr_addr = 8'd7; wr_data = {1'b0, 8'hC3};
    tick();
    wr_en = 1'b0;
    #1;
    check("R3 staged write not yet visible", rd_data2, {^pat(7), pat(7)});
    tick();
    check("R3 staged write visible", rd_data2, {^8'hC3, 8'hC3});

    // R4/R6 queue fill with junk addresses
    fifo_mode = 1'b1; par_en = 1'b1; par_odd = 1'b0;
    tick();
    for (int i = 0; i < 256; i++) begin
      wr_en = 1'b1; wr_addr = ~8'(i); rd_addr = 8'(i * 3); wr_data = {1'b0, 8'(i) ^ 8'hA5};
      tick();
      check("R4 fill count", fill_count, i + 1);
      check("R4 full", full, (i + 1 == 256) ? 1 : 0);
      check("R4 empty", empty, 0);
      check("R6 almost_full", almost_full, (i + 1 >= 250) ? 1 : 0);
      check("R6 almost_empty", almost_empty, (i + 1 <= 3) ? 1 : 0);
    end
    // R5 overflow
    tick();
    wr_en = 1'b0;
    check("R5 overflow pulse", overflow, 1);
    check("R5 count held at full", fill_count, 256);
    tick();
    check("R5 overflow one cycle", overflow, 0);

    // R4 drain in order
    for (int i = 0; i < 256; i++) begin
      rd_en = 1'b1; rd_addr = 8'(255 - i);
      tick();
      check("R4 order", rd_data[7:0], 8'(i) ^ 8'hA5);
      check("R4 read valid", rd_valid, 1);
      check("R4 drain count", fill_count, 255 - i);
      check("R4 empty", empty, (i == 255) ? 1 : 0);
      check("R6 almost_empty drain", almost_empty, (255 - i <= 3) ? 1 : 0);
      check("R6 almost_full drain", almost_full, (255 - i >= 250) ? 1 : 0);
    end
    // R5 underflow
    tick();
    check("R5 underflow pulse", underflow, 1);
    check("R5 no valid on dropped read", rd_valid, 0);
    rd_en = 1'b0;
    tick();
    check("R5 underflow one cycle", underflow, 0);

    // R9 simultaneous read and write at steady level
    for (int k = 0; k < 10; k++) begin
      wr_en = 1'b1; wr_data = {1'b0, 8'(8'h10 + k)};
      tick();
    end
    for (int k = 0; k < 20; k++) begin
      wr_en = 1'b1; rd_en = 1'b1; wr_data = {1'b0, 8'(8'h40 + k)};
      tick();
      check("R9 count steady", fill_count, 10);
      check("R9 order", rd_data[7:0], (k < 10) ? 8'h10 + k : 8'h40 + k - 10);
    end
    wr_en = 1'b0;
    for (int k = 0; k < 10; k++) begin
      rd_en = 1'b1;
      tick();
      check("R9 tail order", rd_data[7:0], 8'h4A + k);
    end
    check("R9 drained", fill_count, 0);

    // R9 read and write on empty queue
    wr_en = 1'b1; rd_en = 1'b1; wr_data = {1'b0, 8'h77};
    tick();
    check("R9 write accepted", fill_count, 1);
    check("R9 no bypass valid", rd_valid, 0);
    check("R5 underflow with write", underflow, 1);
    wr_en = 1'b0;
    tick();
    check("R9 word read next", rd_data[7:0], 8'h77);
    check("R9 valid next", rd_valid, 1);
    rd_en = 1'b0;
    tick();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule